// File: doc/BRIEF.md
# SPI Transmit Push Port with Retained Command Word

This block is the write side of an SPI master's transmit queue. Software or a DMA engine writes a 32-bit push word with byte enables. The upper half of the word holds a 16-bit command that steers the shift engine: chip select, frame size and similar settings. The lower half holds 16 bits of transmit data. The byte enables decide what each write does. A write of all four bytes queues one complete entry. A write that touches only the data half queues one entry, using the command word that was written most recently. A write that touches only the command half queues nothing and only changes the retained command.

With this arrangement a producer can set the command once and then stream data-only writes. This suits a DMA engine that moves one byte or one halfword per request. The queue is four entries deep. The shift engine drains it one entry at a time through a valid/ready handshake. The port also provides full and empty flags, a fill request for the DMA engine, and a sticky overflow flag that is cleared by writing 1 to it. Command-only and data-only narrow writes are honoured only in master mode.

Top module: `spi_tx_push_port`

## Requirements
- R1: After reset the queue is empty (`fifo_empty`=1, `fifo_full`=0, `pop_valid`=0), `ovf_flag`=0, and the retained command word is 0x0000, so the first narrow data write after reset pops with bits [31:16] equal to zero.
- R2: A write with `wr_be`=4'b1111 queues one entry equal to `wr_data`: command in bits [31:16] and data in bits [15:0].
- R3: In master mode, a write whose enables are nonzero only in `wr_be[1:0]` queues one entry: {retained command, data}. In the data half, each byte lane that is not enabled reads as zero. Bit 0 enables data bits [7:0] and bit 1 enables data bits [15:8].
- R4: In master mode, a write whose enables are nonzero only in `wr_be[3:2]` queues nothing. It replaces only the enabled bytes of the retained command. `wr_be[3]` selects command bits [15:8] and `wr_be[2]` selects command bits [7:0].
- R5: A 4'b1111 write also loads its bits [31:16] into the retained command word, and later narrow data writes use that value.
- R6: With `master_mode`=0, narrow writes queue nothing and leave the retained command unchanged, while 4'b1111 writes still queue and still load the command.
- R7: A write with `wr_be`=0, or with enables in both halves that are not all four, queues nothing and leaves the retained command unchanged.
- R8: Entries leave in the order written. `fifo_full` rises once four entries are held. `fifo_empty` and `pop_valid` follow the occupancy. An entry is removed when `pop_valid` and `pop_ready` are both 1.
- R9: A push attempted while the queue is full is discarded and sets `ovf_flag`. The flag holds until `stat_we`=1 with `stat_wdata`=1, and a new overflow in that same cycle wins. Fullness is judged before any pop in the same cycle.
- R10: `fill_req` is 1 exactly when the queue is not full.
- R11: When the queue is neither empty nor full, a push and a pop in the same cycle are both accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_mode | input | 1 | 1 enables narrow command and data writes |
| wr_en | input | 1 | Push-word write strobe |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data: command [31:16], data [15:0] |
| stat_we | input | 1 | Status write strobe |
| stat_wdata | input | 1 | Writing 1 clears the overflow flag |
| pop_valid | output | 1 | Queue head is available |
| pop_ready | input | 1 | Shift engine takes the head |
| pop_data | output | 32 | Queue head entry |
| fifo_full | output | 1 | Four entries held |
| fifo_empty | output | 1 | No entries held |
| fill_req | output | 1 | Request to the DMA engine for more data |
| ovf_flag | output | 1 | Sticky dropped-push flag |

## Verification
The main function is driven with full-word writes, low-byte-only, high-byte-only and halfword data writes, and single-byte and halfword command writes. Each popped entry then shows whether the command half came from reset, from a full write or from a partial command merge, and whether unused data lanes were cleared to zero. Mixed-lane and zero-enable writes, and narrow writes outside master mode, are each followed by a data write whose popped command shows that the retained value did not move. Ordering, fullness and overflow are tested by filling past four entries, both with and without a pop in the same cycle as the extra push.

// File: rtl/spi_push_pkg.sv
// Shared types for the SPI transmit push port.
// Assumes a push word split into two equal halves: command above, data below.
package spi_push_pkg;

    // Classification of one bus write into the push word.
    typedef enum logic [1:0] {
        LANE_NONE = 2'd0,   // nothing happens
        LANE_FULL = 2'd1,   // whole word queued, command reloaded
        LANE_CMD  = 2'd2,   // command bytes merged, nothing queued
        LANE_DATA = 2'd3    // data queued with retained command
    } lane_kind_e;

endpackage

// File: rtl/spi_push_lane_dec.sv
// Byte-lane decoder: sorts each write into full, command-only, data-only or
// ignored, and builds the data half with unwritten lanes cleared to zero.
// Assumes DATA_W is a multiple of 16 so each half is a whole number of bytes.
module spi_push_lane_dec
    import spi_push_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8,
    localparam int HALF  = DATA_W / 2,
    localparam int HBE   = BE_W / 2
) (
    input  logic            wr_en,
    input  logic [BE_W-1:0] wr_be,
    input  logic [HALF-1:0] wr_data_lo,
    input  logic            master_mode,
    output lane_kind_e      kind,
    output logic [HALF-1:0] data_masked
);

    logic [HBE-1:0] be_lo;
    logic [HBE-1:0] be_hi;

    assign be_lo = wr_be[HBE-1:0];
    assign be_hi = wr_be[BE_W-1:HBE];

    // Classify the write from its enables and the mode.
    always_comb begin
        kind = LANE_NONE;
        if (wr_en) begin
            if (&wr_be) begin
                kind = LANE_FULL;
            end else if (master_mode && (be_hi == '0) && (be_lo != '0)) begin
                kind = LANE_DATA;
            end else if (master_mode && (be_lo == '0) && (be_hi != '0)) begin
                kind = LANE_CMD;
            end
        end
    end

    // Clear each data byte whose enable is low.
    for (genvar i = 0; i < HBE; i++) begin : g_mask
        assign data_masked[8*i +: 8] = be_lo[i] ? wr_data_lo[8*i +: 8] : 8'h00;
    end

endmodule

// File: rtl/spi_push_cmd_latch.sv
// Retained command word: bytes are loaded per enable, and reset clears it.
// Assumes one write per cycle; the new value is visible from the next cycle.
module spi_push_cmd_latch #(
    parameter int HALF = 16,
    localparam int HBE = HALF / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [HBE-1:0]  byte_en,
    input  logic [HALF-1:0] wdata,
    output logic [HALF-1:0] cmd_q
);

    for (genvar i = 0; i < HBE; i++) begin : g_byte
        // Hold or reload one command byte.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmd_q[8*i +: 8] <= 8'h00;
            end else if (load && byte_en[i]) begin
                cmd_q[8*i +: 8] <= wdata[8*i +: 8];
            end
        end
    end

endmodule

// File: rtl/spi_push_fifo.sv
// Circular queue with an occupancy counter. A push into a full queue is
// refused and reported through push_drop. Fullness is judged before any pop
// in the same cycle. Storage has no reset; the counter marks valid slots.
module spi_push_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_ready,
    output logic             pop_valid,
    output logic [WIDTH-1:0] pop_data,
    output logic             full,
    output logic             empty,
    output logic             push_drop
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             push_ok;
    logic             pop_ok;

    assign full      = (count == CNT_W'(DEPTH));
    assign empty     = (count == '0);
    assign push_ok   = push_req && !full;
    assign pop_ok    = pop_ready && !empty;
    assign push_drop = push_req && full;
    assign pop_valid = !empty;
    assign pop_data  = mem[rd_ptr];

    // Return the slot after p, wrapping at DEPTH.
    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) begin
            return '0;
        end
        return p + PTR_W'(1);
    endfunction

    // Write an accepted entry into its slot.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= next_ptr(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= next_ptr(rd_ptr);
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/spi_push_ovf.sv
// Sticky overflow flag: set by a dropped push and cleared by a write of 1.
// A set and a clear in the same cycle leave the flag set.
module spi_push_ovf (
    input  logic clk,
    input  logic rst_n,
    input  logic drop,
    input  logic clr,
    output logic flag
);

    // Track the overflow condition; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (drop) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_tx_push_port.sv
// SPI transmit push port. It decodes byte-lane writes to the push word,
// retains the last command, assembles queue entries and exposes the queue
// to the shift engine. It assumes at most one bus write per cycle.
module spi_tx_push_port
    import spi_push_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int BE_W  = DATA_W / 8,
    localparam int HALF  = DATA_W / 2,
    localparam int HBE   = BE_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              wr_en,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              stat_we,
    input  logic              stat_wdata,
    output logic              pop_valid,
    input  logic              pop_ready,
    output logic [DATA_W-1:0] pop_data,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic              fill_req,
    output logic              ovf_flag
);

    lane_kind_e      kind;
    logic [HALF-1:0] data_masked;
    logic [HALF-1:0] cmd_q;
    logic            cmd_load;
    logic [HBE-1:0]  cmd_be;
    logic            push_req;
    logic [DATA_W-1:0] entry;
    logic            push_drop;

    spi_push_lane_dec #(.DATA_W(DATA_W)) u_dec (
        .wr_en       (wr_en),
        .wr_be       (wr_be),
        .wr_data_lo  (wr_data[HALF-1:0]),
        .master_mode (master_mode),
        .kind        (kind),
        .data_masked (data_masked)
    );

    // A full write reloads every command byte; a command write loads its lanes.
    always_comb begin
        cmd_load = (kind == LANE_FULL) || (kind == LANE_CMD);
        cmd_be   = (kind == LANE_FULL) ? '1 : wr_be[BE_W-1:HBE];
    end

    spi_push_cmd_latch #(.HALF(HALF)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cmd_load),
        .byte_en (cmd_be),
        .wdata   (wr_data[DATA_W-1:HALF]),
        .cmd_q   (cmd_q)
    );

    // Build the queue entry: the word as written, or retained command plus data.
    always_comb begin
        push_req = (kind == LANE_FULL) || (kind == LANE_DATA);
        entry    = (kind == LANE_FULL) ? wr_data : {cmd_q, data_masked};
    end

    spi_push_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .push_data (entry),
        .pop_ready (pop_ready),
        .pop_valid (pop_valid),
        .pop_data  (pop_data),
        .full      (fifo_full),
        .empty     (fifo_empty),
        .push_drop (push_drop)
    );

    spi_push_ovf u_ovf (
        .clk   (clk),
        .rst_n (rst_n),
        .drop  (push_drop),
        .clr   (stat_we && stat_wdata),
        .flag  (ovf_flag)
    );

    assign fill_req = !fifo_full;

endmodule

// File: rtl/spi_tx_push_port_chk.sv
// Checker for the push port, bound to every instance of the top module.
module spi_tx_push_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       master_mode,
    input logic       wr_en,
    input logic [3:0] wr_be,
    input logic       stat_we,
    input logic       stat_wdata,
    input logic       pop_valid,
    input logic       pop_ready,
    input logic       fifo_full,
    input logic       fifo_empty,
    input logic       ovf_flag
);

    assert_full_empty_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    assert_full_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !(pop_valid && pop_ready)) |=> fifo_full);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && wr_en && (wr_be == 4'hF)) |=> ovf_flag);

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(stat_we && stat_wdata)) |=> ovf_flag);

    assert_cmd_no_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && wr_en && master_mode && (wr_be[1:0] == 2'b00)
         && (wr_be[3:2] != 2'b00)) |=> fifo_empty);

    assert_push_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && pop_ready && !fifo_full && wr_en && (wr_be == 4'hF))
        |=> !fifo_empty);

endmodule

bind spi_tx_push_port spi_tx_push_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .wr_en       (wr_en),
    .wr_be       (wr_be),
    .stat_we     (stat_we),
    .stat_wdata  (stat_wdata),
    .pop_valid   (pop_valid),
    .pop_ready   (pop_ready),
    .fifo_full   (fifo_full),
    .fifo_empty  (fifo_empty),
    .ovf_flag    (ovf_flag)
);

// File: tb/tb_spi_tx_push_port.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_spi_tx_push_port;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_mode = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = 4'h0;
    logic [31:0] wr_data = 32'h0;
    logic        stat_we = 1'b0;
    logic        stat_wdata = 1'b0;
    logic        pop_valid;
    logic        pop_ready = 1'b0;
    logic [31:0] pop_data;
    logic        fifo_full;
    logic        fifo_empty;
    logic        fill_req;
    logic        ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    spi_tx_push_port dut (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .stat_we(stat_we), .stat_wdata(stat_wdata),
        .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .fill_req(fill_req), .ovf_flag(ovf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 4'h0;
    endtask

    task automatic pop_expect(input string req, input logic [31:0] exp);
        @(negedge clk);
        check(req, {31'b0, pop_valid}, 32'h1);
        check(req, pop_data, exp);
        pop_ready = 1'b1;
        @(negedge clk);
        pop_ready = 1'b0;
    endtask

    task automatic clear_ovf();
        @(negedge clk);
        stat_we = 1'b1; stat_wdata = 1'b1;
        @(negedge clk);
        stat_we = 1'b0; stat_wdata = 1'b0;
    endtask

    // R1, R10: state straight after reset, and the zero command it holds.
    task automatic t_reset();
        check("R1 empty", {31'b0, fifo_empty}, 32'h1);
        check("R1 full", {31'b0, fifo_full}, 32'h0);
        check("R1 valid", {31'b0, pop_valid}, 32'h0);
        check("R1 ovf", {31'b0, ovf_flag}, 32'h0);
        check("R10 fill_req", {31'b0, fill_req}, 32'h1);
        bus_write(4'b0011, 32'hDEAD_1234);
        pop_expect("R1 zero cmd", 32'h0000_1234);
    endtask

    // R2, R5, R3: full write, then a low-byte write reuses its command.
    task automatic t_full();
        bus_write(4'b1111, 32'hA5C3_0042);
        pop_expect("R2 full entry", 32'hA5C3_0042);
        bus_write(4'b0001, 32'hFFFF_FF77);
        pop_expect("R5/R3 reuse cmd, zero-extend", 32'hA5C3_0077);
    endtask

    // R4, R3: command writes queue nothing and merge bytes.
    task automatic t_cmd();
        bus_write(4'b1100, 32'h8001_9999);
        check("R4 no push", {31'b0, fifo_empty}, 32'h1);
        bus_write(4'b0010, 32'h0000_AB11);
        pop_expect("R3 high data byte", 32'h8001_AB00);
        bus_write(4'b1000, 32'h7F22_3333);
        check("R4 byte cmd no push", {31'b0, fifo_empty}, 32'h1);
        bus_write(4'b0011, 32'h0000_5555);
        pop_expect("R4 byte merge", 32'h7F01_5555);
    endtask

    // R6: slave mode ignores narrow writes but honours full ones.
    task automatic t_slave();
        master_mode = 1'b0;
        bus_write(4'b1100, 32'h1111_0000);
        bus_write(4'b0011, 32'h0000_2222);
        check("R6 narrow ignored", {31'b0, fifo_empty}, 32'h1);
        master_mode = 1'b1;
        bus_write(4'b0011, 32'h0000_0005);
        pop_expect("R6 cmd kept", 32'h7F01_0005);
        master_mode = 1'b0;
        bus_write(4'b1111, 32'h3333_4444);
        master_mode = 1'b1;
        pop_expect("R6 full in slave", 32'h3333_4444);
        bus_write(4'b0001, 32'h0000_0009);
        pop_expect("R6 full loads cmd", 32'h3333_0009);
    endtask

    // R7: mixed-lane and zero-enable writes are ignored.
    task automatic t_mixed();
        bus_write(4'b0110, 32'h9999_9999);
        bus_write(4'b0000, 32'h8888_8888);
        check("R7 no push", {31'b0, fifo_empty}, 32'h1);
        bus_write(4'b0011, 32'h0000_00AA);
        pop_expect("R7 cmd kept", 32'h3333_00AA);
    endtask

    // R8, R9, R10: fill, overflow, ordered drain, sticky flag and clear.
    task automatic t_fill();
        for (int i = 1; i <= 4; i++) bus_write(4'b1111, 32'h1000_0000 + i);
        check("R8 full", {31'b0, fifo_full}, 32'h1);
        check("R10 fill_req low", {31'b0, fill_req}, 32'h0);
        bus_write(4'b1111, 32'hBAD0_0005);
        check("R9 ovf set", {31'b0, ovf_flag}, 32'h1);
        for (int i = 1; i <= 4; i++) pop_expect("R8 order", 32'h1000_0000 + i);
        check("R8 empty", {31'b0, fifo_empty}, 32'h1);
        check("R9 sticky", {31'b0, ovf_flag}, 32'h1);
        clear_ovf();
        check("R9 cleared", {31'b0, ovf_flag}, 32'h0);
    endtask

    // R11: push and pop in one cycle with the queue partly filled.
    task automatic t_simul();
        bus_write(4'b1111, 32'h2000_0001);
        bus_write(4'b1111, 32'h2000_0002);
        @(negedge clk);
        check("R11 head", pop_data, 32'h2000_0001);
        wr_en = 1'b1; wr_be = 4'b1111; wr_data = 32'h2000_0003; pop_ready = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 4'h0; pop_ready = 1'b0;
        pop_expect("R11 second", 32'h2000_0002);
        pop_expect("R11 pushed", 32'h2000_0003);
        check("R11 empty", {31'b0, fifo_empty}, 32'h1);
        check("R11 no ovf", {31'b0, ovf_flag}, 32'h0);
    endtask

    // R9: while full, a push with a same-cycle pop is still dropped.
    task automatic t_full_simul();
        for (int i = 1; i <= 4; i++) bus_write(4'b1111, 32'h3000_0000 + i);
        @(negedge clk);
        wr_en = 1'b1; wr_be = 4'b1111; wr_data = 32'h3000_0005; pop_ready = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 4'h0; pop_ready = 1'b0;
        check("R9 ovf on full pop", {31'b0, ovf_flag}, 32'h1);
        check("R9 not full", {31'b0, fifo_full}, 32'h0);
        for (int i = 2; i <= 4; i++) pop_expect("R9 drained", 32'h3000_0000 + i);
        check("R9 empty", {31'b0, fifo_empty}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full();
        t_cmd();
        t_slave();
        t_mixed();
        t_fill();
        t_simul();
        t_full_simul();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule